// File: doc/BRIEF.md
# Serial Command Frame Receiver with Length and Parity Screening

This block is the receive front end of a serial responder. A controller pulls chip select low, toggles the serial clock and sends one command word. The block counts the bits it takes in while selected. When chip select returns high it gives exactly one verdict. The verdict is a valid-frame strobe with the decoded word, a length-error pulse, or a parity-error pulse. A select pulse with no clock edges is dropped without any verdict.

In every transaction the block also shifts a response out on the serial data output. The response is a status byte, then a response word, and both are captured when chip select falls. The surrounding status and register logic uses the read-qualified strobe to clear what it has just reported.

All serial inputs are brought into the system clock domain through a synchronizer. Edge detection runs on the synchronized copies, so the serial clock must run several times slower than the system clock.

Top module: `spi_frame_checker`

## Requirements
- R1: A transaction with exactly 32 serial-clock falling edges whose 32 received bits hold an odd number of ones produces a one-cycle `frame_ok` pulse. Bits arrive MSB first, and the word is split as follows: bit 31 goes to `frame_rw` (1 = write, 0 = read), bits 30..25 to `frame_addr`, and bits 24..1 to `frame_data`. Bit 0 is the parity bit.
- R2: A transaction with between 1 and 31 falling edges, or with more than 32, produces a one-cycle `len_err` pulse and no `frame_ok`.
- R3: A chip-select low period with no serial-clock edges produces no pulse on any verdict output.
- R4: A 32-bit transaction whose bits hold an even number of ones produces a one-cycle `par_err` pulse and no `frame_ok`.
- R5: A transaction with the wrong length reports only `len_err`, whatever its parity.
- R6: `read_ok` pulses together with `frame_ok` when `frame_rw` is 0. It never pulses at any other time.
- R7: While selected, `sdo` carries `status_flags` MSB first, then `rsp_data` MSB first, then zeros. Both inputs are captured at the chip-select falling edge. The first bit is on `sdo` before the first falling edge, and each later bit follows a rising edge. `sdo` is 0 while chip select is high.
- R8: The bit count saturates, so that an over-length frame is detected however long it is. A 96-bit frame gives `len_err`.
- R9: Each chip-select rising edge gives at most one of the three verdicts. `frame_rw`, `frame_addr` and `frame_data` keep their values until the next valid frame.
- R10: After reset, every verdict output, every frame field and `sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in, sampled on sclk falling edge |
| sdo | output | 1 | Serial data out, updated after sclk rising edge |
| status_flags | input | 8 | Status byte shifted out first |
| rsp_data | input | 24 | Response word shifted out after the status byte |
| frame_ok | output | 1 | Valid frame strobe |
| read_ok | output | 1 | Valid read frame strobe |
| len_err | output | 1 | Wrong bit count pulse |
| par_err | output | 1 | Even parity pulse |
| frame_rw | output | 1 | Direction bit of last valid frame |
| frame_addr | output | 6 | Address of last valid frame |
| frame_data | output | 24 | Data of last valid frame |

## Verification
The assertions check on every cycle that at most one verdict is active and that each verdict lasts a single cycle. They also check that the read strobe only comes with a valid read, that the decoded fields change only with `frame_ok`, and that `sdo` is quiet once chip select has been high long enough to pass the synchronizer. The scenarios are needed to show which verdict each bit count and parity gets. The bench sweeps lengths from 0 to 40 and also sends 96 bits. It also checks the exact decoded fields and the order of bits on `sdo`.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;
  localparam int FRAME_BITS = 32;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 24;
  localparam int STAT_W     = 8;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  typedef struct packed {
    logic              rw;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              par;
  } frame_t;

  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_OK   = 2'd1,
    VERD_LEN  = 2'd2,
    VERD_PAR  = 2'd3
  } verdict_e;
endpackage

// File: rtl/spi_fc_sync.sv
module spi_fc_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [W-1:0] src;
      if (i == 0) begin : g_first
        assign src = d;
      end else begin : g_rest
        assign src = stg_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= src;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_fc_rx.sv
module spi_fc_rx
  import spi_fc_pkg::*;
#(
  parameter int NBITS = FRAME_BITS,
  parameter int CW    = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bit_stb,
  input  logic             bit_in,
  output logic [NBITS-1:0] shreg,
  output logic [CW-1:0]    bit_cnt
);
  localparam logic [CW-1:0] CNT_SAT = CW'(NBITS + 1);

  logic [NBITS-1:0] shreg_d;
  logic [CW-1:0]    cnt_d;
  logic             sh_en, cnt_en;

  always_comb begin
    sh_en   = bit_stb;
    shreg_d = {shreg[NBITS-2:0], bit_in};
    cnt_en  = start | (bit_stb & (bit_cnt != CNT_SAT));
    cnt_d   = start ? '0 : bit_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      if (sh_en)  shreg   <= shreg_d;
      if (cnt_en) bit_cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/spi_fc_check.sv
module spi_fc_check
  import spi_fc_pkg::*;
#(
  parameter int NBITS = FRAME_BITS,
  parameter int CW    = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close,
  input  logic [NBITS-1:0]  word,
  input  logic [CW-1:0]     bit_cnt,
  output logic              frame_ok,
  output logic              read_ok,
  output logic              len_err,
  output logic              par_err,
  output logic              frame_rw,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [DATA_W-1:0] frame_data
);
  frame_t   fr;
  verdict_e verd;
  logic     fld_en;

  assign fr = frame_t'(word);

  always_comb begin
    verd = VERD_NONE;
    if (close && bit_cnt != '0) begin
      if (bit_cnt != CW'(NBITS)) verd = VERD_LEN;
      else if (!(^word))         verd = VERD_PAR;
      else                       verd = VERD_OK;
    end
    fld_en = (verd == VERD_OK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_ok <= 1'b0;
      read_ok  <= 1'b0;
      len_err  <= 1'b0;
      par_err  <= 1'b0;
    end else begin
      frame_ok <= (verd == VERD_OK);
      read_ok  <= (verd == VERD_OK) && !fr.rw;
      len_err  <= (verd == VERD_LEN);
      par_err  <= (verd == VERD_PAR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_rw   <= 1'b0;
      frame_addr <= '0;
      frame_data <= '0;
    end else if (fld_en) begin
      frame_rw   <= fr.rw;
      frame_addr <= fr.addr;
      frame_data <= fr.data;
    end
  end
endmodule

// File: rtl/spi_fc_tx.sv
module spi_fc_tx
  import spi_fc_pkg::*;
#(
  parameter int SW = STAT_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          sel,
  input  logic [SW-1:0] status,
  input  logic [DW-1:0] rsp,
  output logic          sdo
);
  localparam int TW = SW + DW;

  logic [TW-1:0] tx_q, tx_d;
  logic          tx_en;

  always_comb begin
    tx_en = load | shift;
    tx_d  = load ? {status, rsp} : {tx_q[TW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (tx_en) tx_q <= tx_d;
  end

  assign sdo = sel & tx_q[TW-1];
endmodule

// File: rtl/spi_frame_checker.sv
module spi_frame_checker
  import spi_fc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  input  logic [STAT_W-1:0] status_flags,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              frame_ok,
  output logic              read_ok,
  output logic              len_err,
  output logic              par_err,
  output logic              frame_rw,
  output logic [ADDR_W-1:0] frame_addr,
  output logic [DATA_W-1:0] frame_data
);
  logic [2:0]       sync_q;
  logic             cs_s, sclk_s, sdi_s;
  logic             cs_prev, sclk_prev;
  logic             cs_fall, cs_rise, sck_fall, sck_rise;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0] bit_cnt;

  spi_fc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(sync_q)
  );

  assign {cs_s, sclk_s, sdi_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_prev   <= cs_s;
      sclk_prev <= sclk_s;
    end
  end

  always_comb begin
    cs_fall  = cs_prev & ~cs_s;
    cs_rise  = ~cs_prev & cs_s;
    sck_fall = sclk_prev & ~sclk_s & ~cs_s;
    sck_rise = ~sclk_prev & sclk_s & ~cs_s;
  end

  spi_fc_rx u_rx (
    .clk(clk), .rst_n(rst_n), .start(cs_fall), .bit_stb(sck_fall),
    .bit_in(sdi_s), .shreg(shreg), .bit_cnt(bit_cnt)
  );

  spi_fc_check u_chk (
    .clk(clk), .rst_n(rst_n), .close(cs_rise), .word(shreg), .bit_cnt(bit_cnt),
    .frame_ok(frame_ok), .read_ok(read_ok), .len_err(len_err), .par_err(par_err),
    .frame_rw(frame_rw), .frame_addr(frame_addr), .frame_data(frame_data)
  );

  spi_fc_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(cs_fall),
    .shift(sck_rise && (bit_cnt != '0)), .sel(~cs_s),
    .status(status_flags), .rsp(rsp_data), .sdo(sdo)
  );
endmodule

// File: rtl/spi_frame_checker_chk.sv
module spi_frame_checker_chk
  import spi_fc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sdo,
  input logic              frame_ok,
  input logic              read_ok,
  input logic              len_err,
  input logic              par_err,
  input logic              frame_rw,
  input logic [ADDR_W-1:0] frame_addr,
  input logic [DATA_W-1:0] frame_data
);
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_ok, len_err, par_err})); // R9
  AST_OK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok); // R1
  AST_LEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> !len_err); // R2
  AST_PAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> !par_err); // R4
  AST_READ_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |-> (frame_ok && !frame_rw)); // R6
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |-> ($stable(frame_rw) && $stable(frame_addr) && $stable(frame_data))); // R9
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo); // R7
endmodule

bind spi_frame_checker spi_frame_checker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo),
  .frame_ok(frame_ok), .read_ok(read_ok), .len_err(len_err), .par_err(par_err),
  .frame_rw(frame_rw), .frame_addr(frame_addr), .frame_data(frame_data)
);

// File: tb/spi_frame_checker_tb_top.sv
module spi_frame_checker_tb_top;
  logic        clk, rst_n, cs_n, sclk, sdi;
  logic        sdo;
  logic [7:0]  status_flags;
  logic [23:0] rsp_data;
  logic        frame_ok, read_ok, len_err, par_err, frame_rw;
  logic [5:0]  frame_addr;
  logic [23:0] frame_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic        exp_rw;
  logic [5:0]  exp_addr;
  logic [23:0] exp_data;

  spi_frame_checker dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .status_flags(status_flags), .rsp_data(rsp_data),
    .frame_ok(frame_ok), .read_ok(read_ok), .len_err(len_err), .par_err(par_err),
    .frame_rw(frame_rw), .frame_addr(frame_addr), .frame_data(frame_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nb bits of v MSB first, then reports pulse counts in the verdict window.
  task automatic xfer(input int nb, input logic [127:0] v, input string tag);
    int cok = 0, crd = 0, clen = 0, cpar = 0;
    logic [31:0] got = '0;
    logic [31:0] expo;
    int ones = 0;
    int nc;
    logic        ex_ok, ex_len, ex_par;
    status_flags = 8'($urandom);
    rsp_data     = 24'($urandom);
    expo = {status_flags, rsp_data};
    cs_n = 1'b0;
    wclk(6);
    for (int i = 0; i < nb; i++) begin
      sdi = v[nb-1-i];
      ones += v[nb-1-i];
      wclk(4);
      sclk = 1'b1;
      wclk(4);
      if (i < 32) got[31-i] = sdo;
      else check(sdo == 1'b0, "R7 trailing", sdo, 0);
      sclk = 1'b0;
      wclk(2);
    end
    wclk(4);
    cs_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      wclk(1);
      cok += frame_ok; crd += read_ok; clen += len_err; cpar += par_err;
    end
    ex_ok  = (nb == 32) && (ones % 2 == 1);
    ex_len = (nb != 0) && (nb != 32);
    ex_par = (nb == 32) && (ones % 2 == 0);
    if (ex_ok) begin
      exp_rw   = v[31];
      exp_addr = v[30:25];
      exp_data = v[24:1];
    end
    check(cok == int'(ex_ok), {tag, " R1 frame_ok count"}, cok, ex_ok);
    check(clen == int'(ex_len), {tag, " R2 len_err count"}, clen, ex_len);
    check(cpar == int'(ex_par), {tag, " R4 par_err count"}, cpar, ex_par);
    check(crd == int'(ex_ok && !v[31]), {tag, " R6 read_ok count"}, crd, ex_ok && !v[31]);
    check({frame_rw, frame_addr, frame_data} == {exp_rw, exp_addr, exp_data},
          {tag, " R9 fields"}, {frame_rw, frame_addr, frame_data}, {exp_rw, exp_addr, exp_data});
    nc = (nb < 32) ? nb : 32;
    if (nc > 0)
      check((got >> (32 - nc)) == (expo >> (32 - nc)), {tag, " R7 sdo bits"},
            got >> (32 - nc), expo >> (32 - nc));
    check(sdo == 1'b0, {tag, " R7 idle sdo"}, sdo, 0);
    wclk(4);
  endtask

  function automatic logic [127:0] mkw(input bit odd, input bit rw);
    logic [31:0] w;
    w = $urandom;
    w[31] = rw;
    w[0]  = odd ? ~(^w[31:1]) : (^w[31:1]);
    return {96'b0, w};
  endfunction

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 190000) begin
        check(1'b0, "watchdog", wd, 190000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [127:0] v;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    status_flags = '0; rsp_data = '0;
    exp_rw = 1'b0; exp_addr = '0; exp_data = '0;
    wclk(4);
    check({frame_ok, read_ok, len_err, par_err, sdo} == 5'b0, "R10 reset pulses", 0, 0);
    check({frame_rw, frame_addr, frame_data} == 31'b0, "R10 reset fields",
          {frame_rw, frame_addr, frame_data}, 0);
    rst_n = 1'b1;
    wclk(4);

    xfer(0, '0, "R3 empty select");
    xfer(32, mkw(1, 1), "R1 write ok");
    xfer(32, mkw(1, 0), "R1 R6 read ok");
    xfer(32, mkw(0, 0), "R4 even read");
    xfer(32, mkw(0, 1), "R4 even write");
    xfer(32, {96'b0, 32'h0000_0001}, "R1 single one");
    xfer(32, {96'b0, 32'hFFFF_FFFF}, "R4 all ones");
    // Length sweep, random parity: R2 and R5
    for (int n = 0; n <= 40; n++) begin
      v = {$urandom, $urandom, $urandom, $urandom};
      if (n == 32) v = mkw(1, n[0]);
      xfer(n, v, "R2 R5 sweep");
    end
    // Even ones on wrong lengths: only len_err
    xfer(31, {97'b0, 31'h0000_0003}, "R5 short even");
    xfer(33, {95'b0, 33'h0_0000_0003}, "R5 long even");
    // Saturation: 96 bits would alias to 32 in a 6-bit wrapping count
    v = {$urandom, $urandom, $urandom, $urandom};
    xfer(96, v, "R8 96 bits");
    xfer(0, '0, "R3 empty again");
    xfer(32, mkw(1, 0), "R1 R6 final read");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule